// File: doc/BRIEF.md
# Polyphase Coefficient Address Sequencer

This block drives the address side of a polyphase FIR convolution inside an asynchronous sample rate converter. Each time an output sample is due, a rate tracker hands it an integer read position in the input sample FIFO and a 16-bit phase word. The phase word measures how far into the current input period the output request fell. The block captures both values on a start strobe. It then emits one address pair per clock, one pair for each filter tap, flagging the final pair.

Each pair holds a FIFO read address and a coefficient ROM address. The FIFO address walks backwards from the captured base. The ROM address selects the same polyphase branch for every tap. The branch number comes from the upper bits of the phase, so a late request, which has a large phase, lands at a large offset into the coefficient array and gives a short filter delay. The leftover low phase bits are held on a separate output for an optional interpolator.

The block also reports how far the read base moved since the previous output event. A move of zero, one or two samples is normal. Any other move marks a sticky error. A strobe that arrives in the middle of a sequence is dropped and flagged.

Top module: `pps_addr_seq`

## Requirements
- R1: After reset, valid_o, last_o, overrun_o and step_err_o are 0 and step_o is 0.
- R2: A start accepted at a clock edge makes valid_o high for exactly TAPS (default 32) consecutive cycles, beginning with the cycle after that edge. last_o is high only in the final one of those cycles.
- R3: In tap cycle k (k = 0 first), fifo_addr_o equals the captured base minus k, modulo 2^FIFO_AW (default 64).
- R4: In tap cycle k, rom_addr_o equals k*256 plus phase bits [15:8]. A larger phase therefore gives a larger offset. frac_o shows phase bits [7:0] for the whole sequence.
- R5: A start that comes in a tap cycle other than the last is ignored, so the running sequence continues unchanged. It also sets overrun_o, which stays set until reset.
- R6: A start in the cycle where last_o is high is accepted. The next sequence begins in the following cycle with no gap, and overrun_o is not set.
- R7: On each accepted start, step_o takes (new base minus previous accepted base) mod 2^FIFO_AW when that value is 0, 1 or 2, and it is visible from the first tap cycle. The first start after reset gives step_o = 0.
- R8: Any other difference gives step_o = 3 and sets step_err_o, which stays set until reset. Later valid steps update step_o but leave step_err_o set.
- R9: Changes on base_i and phase_i without an accepted start have no effect on the addresses being emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Output event strobe, one cycle |
| base_i | input | FIFO_AW | Integer FIFO read base |
| phase_i | input | PHASE_W | Fractional phase word |
| fifo_addr_o | output | FIFO_AW | FIFO read address for the current tap |
| rom_addr_o | output | TAP_W+ROM_PH_W | Coefficient ROM address for the current tap |
| frac_o | output | PHASE_W-ROM_PH_W | Low phase bits for an interpolator |
| valid_o | output | 1 | Address pair valid |
| last_o | output | 1 | Final tap of the sequence |
| step_o | output | 2 | Base movement since last event, 3 means out of range |
| step_err_o | output | 1 | Sticky out-of-range step flag |
| overrun_o | output | 1 | Sticky ignored-start flag |

## Verification
A corrupted tap counter would show up within the same sequence. The sequence length would differ from TAPS, last_o would appear on the wrong cycle, or the FIFO addresses would stop decreasing by one each cycle. A wrong captured phase or base shows on the very first tap cycle after start as a bad ROM branch or FIFO address. Stale step tracking shows on the next accepted start as a wrong step_o or a spurious sticky error. A start accepted when it should have been dropped breaks the address run at the next cycle.

// File: rtl/aseq_pkg.sv
// Package: shared constants and types for the polyphase address sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package aseq_pkg;
    // Step code reported when the base moved by something other than 0..2.
    localparam logic [1:0] STEP_BAD = 2'd3;

    // Largest base movement treated as normal.
    localparam int STEP_MAX = 2;
endpackage

// File: rtl/aseq_tap_ctrl.sv
// Module: tap sequencing control.
// Counts taps after an accepted start and decides whether a start is
// taken or dropped. A start is taken when idle or on the final tap.
// Assumes: TAPS >= 2.
module aseq_tap_ctrl #(
    parameter int TAPS  = 32,
    localparam int TAP_W = $clog2(TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             accept_o,
    output logic             busy_o,
    output logic             is_last_o,
    output logic [TAP_W-1:0] tap_o,
    output logic             overrun_o
);
    logic             busy_q;
    logic [TAP_W-1:0] tap_q;
    logic             ovr_q;

    // Purpose: flag the final tap and qualify an incoming start.
    always_comb begin
        is_last_o = busy_q && (tap_q == TAP_W'(TAPS - 1));
        accept_o  = start_i && (!busy_q || is_last_o);
    end

    // Purpose: advance the tap counter and busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            tap_q  <= '0;
        end else if (accept_o) begin
            busy_q <= 1'b1;
            tap_q  <= '0;
        end else if (busy_q) begin
            if (is_last_o) begin
                busy_q <= 1'b0;
                tap_q  <= '0;
            end else begin
                tap_q <= tap_q + 1'b1;
            end
        end
    end

    // Purpose: remember any start dropped in mid sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
        end else if (start_i && busy_q && !is_last_o) begin
            ovr_q <= 1'b1;
        end
    end

    assign busy_o    = busy_q;
    assign tap_o     = tap_q;
    assign overrun_o = ovr_q;
endmodule

// File: rtl/aseq_addr_gen.sv
// Module: address pair generator.
// Captures base and phase on an accepted start. It forms the FIFO
// address as base minus tap, modulo the FIFO depth. It forms the ROM
// address as tap times the branch count plus the upper phase bits.
// Assumes: the branch count is a power of two (2^ROM_PH_W).
module aseq_addr_gen #(
    parameter int TAPS     = 32,
    parameter int FIFO_AW  = 6,
    parameter int PHASE_W  = 16,
    parameter int ROM_PH_W = 8,
    localparam int TAP_W   = $clog2(TAPS),
    localparam int FRAC_W  = PHASE_W - ROM_PH_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      accept_i,
    input  logic [FIFO_AW-1:0]        base_i,
    input  logic [PHASE_W-1:0]        phase_i,
    input  logic [TAP_W-1:0]          tap_i,
    output logic [FIFO_AW-1:0]        fifo_addr_o,
    output logic [TAP_W+ROM_PH_W-1:0] rom_addr_o,
    output logic [FRAC_W-1:0]         frac_o
);
    logic [FIFO_AW-1:0] base_q;
    logic [PHASE_W-1:0] phase_q;

    // Purpose: hold base and phase for the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            phase_q <= '0;
        end else if (accept_i) begin
            base_q  <= base_i;
            phase_q <= phase_i;
        end
    end

    // Purpose: build the address pair for the current tap.
    always_comb begin
        fifo_addr_o = base_q - FIFO_AW'(tap_i);
        rom_addr_o  = {tap_i, phase_q[PHASE_W-1 -: ROM_PH_W]};
        frac_o      = phase_q[FRAC_W-1:0];
    end
endmodule

// File: rtl/aseq_step_mon.sv
// Module: read base step monitor.
// On each accepted start, compares the new base with the previous one
// modulo the FIFO depth. A move of 0..2 is reported as is, anything
// else as the bad code with a sticky error.
// Assumes: the first start after reset has no previous base.
module aseq_step_mon #(
    parameter int FIFO_AW = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               accept_i,
    input  logic [FIFO_AW-1:0] base_i,
    output logic [1:0]         step_o,
    output logic               step_err_o
);
    import aseq_pkg::*;

    logic [FIFO_AW-1:0] prev_q;
    logic               have_prev_q;
    logic [FIFO_AW-1:0] diff;
    logic [1:0]         step_q;
    logic               err_q;

    // Purpose: distance moved by the base, modulo the FIFO depth.
    always_comb diff = base_i - prev_q;

    // Purpose: register the step code and sticky error per start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q      <= '0;
            have_prev_q <= 1'b0;
            step_q      <= 2'd0;
            err_q       <= 1'b0;
        end else if (accept_i) begin
            prev_q      <= base_i;
            have_prev_q <= 1'b1;
            if (!have_prev_q) begin
                step_q <= 2'd0;
            end else if (diff <= FIFO_AW'(STEP_MAX)) begin
                step_q <= diff[1:0];
            end else begin
                step_q <= STEP_BAD;
                err_q  <= 1'b1;
            end
        end
    end

    assign step_o     = step_q;
    assign step_err_o = err_q;
endmodule

// File: rtl/pps_addr_seq.sv
// Module: polyphase coefficient address sequencer (top).
// On each accepted output event, emits TAPS paired FIFO and coefficient
// ROM addresses, one per clock, and reports the base step.
// Assumes: start_i is a one-cycle strobe; synchronous active-low reset.
module pps_addr_seq #(
    parameter int TAPS     = 32,
    parameter int FIFO_AW  = 6,
    parameter int PHASE_W  = 16,
    parameter int ROM_PH_W = 8,
    localparam int TAP_W   = $clog2(TAPS),
    localparam int FRAC_W  = PHASE_W - ROM_PH_W
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [FIFO_AW-1:0]        base_i,
    input  logic [PHASE_W-1:0]        phase_i,
    output logic [FIFO_AW-1:0]        fifo_addr_o,
    output logic [TAP_W+ROM_PH_W-1:0] rom_addr_o,
    output logic [FRAC_W-1:0]         frac_o,
    output logic                      valid_o,
    output logic                      last_o,
    output logic [1:0]                step_o,
    output logic                      step_err_o,
    output logic                      overrun_o
);
    logic             accept;
    logic             busy;
    logic             is_last;
    logic [TAP_W-1:0] tap;

    aseq_tap_ctrl #(.TAPS(TAPS)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .accept_o  (accept),
        .busy_o    (busy),
        .is_last_o (is_last),
        .tap_o     (tap),
        .overrun_o (overrun_o)
    );

    aseq_addr_gen #(
        .TAPS(TAPS), .FIFO_AW(FIFO_AW), .PHASE_W(PHASE_W), .ROM_PH_W(ROM_PH_W)
    ) i_addr (
        .clk         (clk),
        .rst_n       (rst_n),
        .accept_i    (accept),
        .base_i      (base_i),
        .phase_i     (phase_i),
        .tap_i       (tap),
        .fifo_addr_o (fifo_addr_o),
        .rom_addr_o  (rom_addr_o),
        .frac_o      (frac_o)
    );

    aseq_step_mon #(.FIFO_AW(FIFO_AW)) i_step (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_i   (accept),
        .base_i     (base_i),
        .step_o     (step_o),
        .step_err_o (step_err_o)
    );

    assign valid_o = busy;
    assign last_o  = is_last;
endmodule

// File: rtl/pps_addr_seq_chk.sv
// Module: assertion checker for the address sequencer, bound to the top.
// Assumes: same parameters as the instance it is bound to.
module pps_addr_seq_chk #(
    parameter int TAPS     = 32,
    parameter int FIFO_AW  = 6,
    parameter int PHASE_W  = 16,
    parameter int ROM_PH_W = 8,
    localparam int TAP_W   = $clog2(TAPS),
    localparam int FRAC_W  = PHASE_W - ROM_PH_W
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      start_i,
    input logic [FIFO_AW-1:0]        fifo_addr_o,
    input logic [TAP_W+ROM_PH_W-1:0] rom_addr_o,
    input logic [FRAC_W-1:0]         frac_o,
    input logic                      valid_o,
    input logic                      last_o,
    input logic [1:0]                step_o,
    input logic                      step_err_o,
    input logic                      overrun_o
);
    localparam int NPH = 1 << ROM_PH_W;

    p_last_in_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o);

    p_seq_continues_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> valid_o);

    p_fifo_walks_back_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> fifo_addr_o == FIFO_AW'($past(fifo_addr_o) - 1));

    p_rom_stride_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=>
            rom_addr_o == (TAP_W+ROM_PH_W)'($past(rom_addr_o) + NPH));

    p_frac_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o) |=> $stable(frac_o));

    p_overrun_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        overrun_o |=> overrun_o);

    p_overrun_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun_o) |-> $past(start_i && valid_o && !last_o));

    p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        step_err_o |=> step_err_o);

    p_bad_step_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o == 2'd3) |-> step_err_o);
endmodule

bind pps_addr_seq pps_addr_seq_chk #(
    .TAPS(TAPS), .FIFO_AW(FIFO_AW), .PHASE_W(PHASE_W), .ROM_PH_W(ROM_PH_W)
) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .fifo_addr_o (fifo_addr_o),
    .rom_addr_o  (rom_addr_o),
    .frac_o      (frac_o),
    .valid_o     (valid_o),
    .last_o      (last_o),
    .step_o      (step_o),
    .step_err_o  (step_err_o),
    .overrun_o   (overrun_o)
);

// File: tb/test_pps_addr_seq.sv
// Bench: directed tests for the polyphase address sequencer.
module test_pps_addr_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TAPS  = 32;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [5:0]  base_i;
    logic [15:0] phase_i;
    logic [5:0]  fifo_addr_o;
    logic [12:0] rom_addr_o;
    logic [7:0]  frac_o;
    logic        valid_o, last_o, step_err_o, overrun_o;
    logic [1:0]  step_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;
    int prev_base = -1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pps_addr_seq i_pps_addr_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .phase_i(phase_i), .fifo_addr_o(fifo_addr_o), .rom_addr_o(rom_addr_o),
        .frac_o(frac_o), .valid_o(valid_o), .last_o(last_o), .step_o(step_o),
        .step_err_o(step_err_o), .overrun_o(overrun_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected step code from the requirements (R7, R8).
    function automatic int exp_step(input int b);
        int d;
        if (prev_base < 0) return 0;
        d = (b - prev_base + DEPTH) % DEPTH;
        return (d <= 2) ? d : 3;
    endfunction

    // Run one sequence. pre=1: start already issued. inj: tap at which a
    // stray start is issued (-1 none). chain: issue start nb/np on last tap.
    task automatic run_seq(input int b, input int p, input bit pre,
                           input int inj, input bit chain,
                           input int nb, input int np);
        int es;
        es = exp_step(b);
        prev_base = b;
        if (!pre) begin
            start_i = 1'b1; base_i = 6'(b); phase_i = 16'(p);
            @(negedge clk);
        end
        start_i = 1'b0;
        for (int k = 0; k < TAPS; k++) begin
            // R9: scramble inputs while the sequence runs
            base_i  = 6'(b + 17 + k);
            phase_i = 16'(p ^ (16'h5A5A + k));
            chk("R2 valid", int'(valid_o), 1);
            chk("R2 last", int'(last_o), (k == TAPS - 1) ? 1 : 0);
            chk("R3 fifo addr", int'(fifo_addr_o), (b - k + DEPTH) % DEPTH);
            chk("R4 rom addr", int'(rom_addr_o), k * 256 + ((p >> 8) & 255));
            chk("R4 frac", int'(frac_o), p & 255);
            chk("R7 step", int'(step_o), es);
            if (k == inj) begin
                start_i = 1'b1; base_i = 6'(b + 20); phase_i = 16'h0000;
            end
            if (k < TAPS - 1) begin
                @(negedge clk);
                start_i = 1'b0;
            end
        end
        if (chain) begin
            start_i = 1'b1; base_i = 6'(nb); phase_i = 16'(np);
            @(negedge clk);
        end else begin
            @(negedge clk);
            chk("R2 idle after last", int'(valid_o), 0);
            chk("R2 last low", int'(last_o), 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start_i = 1'b0; base_i = '0; phase_i = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid", int'(valid_o), 0);
        chk("R1 last", int'(last_o), 0);
        chk("R1 overrun", int'(overrun_o), 0);
        chk("R1 step_err", int'(step_err_o), 0);
        chk("R1 step", int'(step_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_basic();
        run_seq(5, 16'h1234, 0, -1, 0, 0, 0);   // R7 first start: step 0
        run_seq(6, 16'hF0AB, 0, -1, 0, 0, 0);   // step 1, address wrap R3
        run_seq(8, 16'h00FF, 0, -1, 0, 0, 0);   // step 2, small offset R4
        chk("R8 no error yet", int'(step_err_o), 0);
    endtask

    task automatic t_chain();
        run_seq(8, 16'h8000, 0, -1, 1, 9, 16'hC301);  // step 0
        run_seq(9, 16'hC301, 1, -1, 0, 0, 0);         // R6 back to back
        chk("R6 no overrun", int'(overrun_o), 0);
    endtask

    task automatic t_overrun();
        run_seq(10, 16'h4477, 0, 3, 0, 0, 0);   // R5 stray start at tap 3
        chk("R5 overrun sticky", int'(overrun_o), 1);
    endtask

    task automatic t_step_err();
        run_seq(31, 16'h2200, 0, -1, 0, 0, 0);  // R8 jump of 21
        chk("R8 error set", int'(step_err_o), 1);
        run_seq(32, 16'h2300, 0, -1, 0, 0, 0);  // valid step, error stays
        chk("R8 error sticky", int'(step_err_o), 1);
        run_seq(0, 16'h2400, 0, -1, 0, 0, 0);   // R8 backwards jump 32
        chk("R8 error after jump", int'(step_err_o), 1);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_chain();
        t_overrun();
        t_step_err();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule